// File: doc/BRIEF.md
# Touch Detection Integrator with Guard Key

This block turns per-acquisition capacitive readings into a debounced touch state for each key. On every acquisition strobe it receives, for each key, the measured signal, the calibrated base value and a touch threshold. A key counts as qualifying when its signal has dropped below its base by more than its threshold. A per-key counter has to reach a shared debounce limit on consecutive acquisitions before the key enters detect. The same consecutive count, of non-qualifying acquisitions, is needed before it leaves detect.

Two suppression rules sit between the counters and the detect state. Among ordinary keys, at most one may newly enter detect per acquisition, and the lowest index wins. An optional guard key can be named. While it is in detect, no ordinary key may enter. It may not enter itself while any ordinary key is still in detect. A key that is blocked keeps its counter at the limit, so it enters on the first later acquisition where it still qualifies and is no longer blocked. An active-low change output either latches any detect transition until the host reads status, or simply shows that some key is touched.

Top module: `touch_guard_di`

## Requirements
- R1: A key qualifies only when base > signal and (base − signal) > threshold, strictly; a difference equal to the threshold does not qualify.
- R2: A key not in detect enters detect on the acquisition that gives it its limit-th consecutive qualifying reading; a limit of 0 behaves as 1. Detect becomes visible the cycle after that strobe.
- R3: A non-qualifying acquisition clears the entry count of a key not in detect, so the qualifying readings must be consecutive.
- R4: A key in detect leaves it on its limit-th consecutive non-qualifying acquisition; a qualifying acquisition while in detect clears that count.
- R5: A key whose threshold is 0 is unused: it never qualifies and never enters detect, whatever its signal.
- R6: At most one ordinary key enters detect per acquisition, the lowest index among the eligible ones. A key that reaches its limit but is not granted holds its count and enters on the next acquisition where it still qualifies and is unblocked.
- R7: With the guard enable set to 1, while the key chosen by the guard index is in detect, no other key may enter detect. With the enable at 0, that key behaves as an ordinary key.
- R8: The guard key may not enter detect while any ordinary key is in detect. It enters on the first acquisition, judged on the state before that strobe, where no ordinary key is in detect.
- R9: With the mode input at 0 (data mode), change_n goes low after any detect transition and stays low until a status read strobe. A read in the same cycle as a new transition leaves change_n low.
- R10: With the mode input at 1 (touch mode), change_n is 0 while any key is in detect and 1 otherwise, with no read needed.
- R11: After reset, all detect bits are 0 and change_n is 1.
- R12: Cycles without the acquisition strobe leave detect state and counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_valid | input | 1 | Acquisition strobe, one cycle per reading set |
| sig_flat | input | NKEYS*SIG_W | Packed signals, key k at bits k*SIG_W upward |
| base_flat | input | NKEYS*SIG_W | Packed base values, same packing |
| thr_flat | input | NKEYS*THR_W | Packed thresholds, 0 marks an unused key |
| di_limit | input | DI_W | Consecutive-reading debounce limit |
| guard_en | input | 1 | 1 enables the guard rule |
| guard_idx | input | IDX_W | Index of the guard key |
| change_mode | input | 1 | 0 data mode, 1 touch mode |
| status_rd | input | 1 | Host read of all key states, one-cycle strobe |
| detect | output | NKEYS | Debounced detect state per key |
| change_n | output | 1 | Active-low change indicator |

## Verification
Two pairs of functions can act in the same cycle. A status read can coincide with a detect transition, and the guard key's exit can coincide with an ordinary key's wish to enter. The bench provokes the first by raising the read strobe together with the acquisition that completes a key's count. It expects change_n to stay low, because that transition has not been reported. It provokes the second by holding an ordinary key qualifying throughout the guard key's exit. The ordinary key must stay out on the exit acquisition itself and enter on the next one, because its count was held at the limit.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
  parameter int SIG_W = 12;
  parameter int THR_W = 8;
  parameter int DI_W  = 8;

  // True when the signal has dropped under the base by more than the threshold.
  function automatic logic key_qualifies(input logic [SIG_W-1:0] sig,
                                         input logic [SIG_W-1:0] base,
                                         input logic [THR_W-1:0] thr);
    logic [SIG_W-1:0] delta;
    delta = base - sig;
    return (thr != '0) && (base > sig) && (delta > SIG_W'(thr));
  endfunction

  // True when one more counted reading meets or passes the limit.
  function automatic logic limit_reached(input logic [DI_W-1:0] cnt,
                                         input logic [DI_W-1:0] limit);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
  endfunction
endpackage

// File: rtl/tdi_key_integ.sv
module tdi_key_integ
  import tdi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_valid,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SIG_W-1:0] base_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [DI_W-1:0]  limit_i,
  input  logic             grant_i,
  output logic             det_o,
  output logic             enter_req_o,
  output logic             exit_evt_o
);
  logic [DI_W-1:0] cnt;
  logic            qual;
  logic            reached;

  assign qual        = key_qualifies(sig_i, base_i, thr_i);
  assign reached     = limit_reached(cnt, limit_i);
  assign enter_req_o = acq_valid & ~det_o & qual & reached;
  assign exit_evt_o  = acq_valid & det_o & ~qual & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_o <= 1'b0;
      cnt   <= '0;
    end else if (acq_valid) begin
      if (!det_o) begin
        if (!qual)          cnt <= '0;
        else if (!reached)  cnt <= cnt + 1'b1;
        else if (grant_i) begin
          det_o <= 1'b1;
          cnt   <= '0;
        end
      end else begin
        if (qual)           cnt <= '0;
        else if (reached) begin
          det_o <= 1'b0;
          cnt   <= '0;
        end else            cnt <= cnt + 1'b1;
      end
    end
  end

  AST_ENTER_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_o) |-> $past(grant_i && enter_req_o)); // R6
  AST_EXIT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_o) |-> $past(exit_evt_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_valid |=> $stable(det_o) && $stable(cnt)); // R12
endmodule

// File: rtl/tdi_guard_arb.sv
module tdi_guard_arb #(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     enter_req_i,
  input  logic [N-1:0]     det_i,
  input  logic             guard_en_i,
  input  logic [IDX_W-1:0] guard_idx_i,
  output logic [N-1:0]     grant_o,
  output logic [N-1:0]     guard_mask_o
);
  logic normal_det_any;
  logic guard_det;
  logic guard_grant;
  logic block_normal;

  for (genvar k = 0; k < N; k++) begin : g_mask
    assign guard_mask_o[k] = guard_en_i && (guard_idx_i == IDX_W'(k));
  end

  assign normal_det_any = |(det_i & ~guard_mask_o);
  assign guard_det      = |(det_i & guard_mask_o);
  assign guard_grant    = (|(enter_req_i & guard_mask_o)) && !normal_det_any;
  assign block_normal   = guard_det || guard_grant;

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int k = 0; k < N; k++) begin
      if (enter_req_i[k] && !guard_mask_o[k] && !block_normal && !found) begin
        grant_o[k] = 1'b1;
        found      = 1'b1;
      end
    end
    grant_o = grant_o | (guard_mask_o & {N{guard_grant}});
  end

  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o & ~guard_mask_o)); // R6
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~enter_req_i) == '0); // R6
  AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(det_i & guard_mask_o)) |-> ((grant_o & ~guard_mask_o) == '0)); // R7
endmodule

// File: rtl/tdi_change.sv
module tdi_change #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] det_i,
  input  logic [N-1:0] trans_i,
  input  logic         mode_i,
  input  logic         status_rd_i,
  output logic         change_n_o
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pend <= 1'b0;
    else if (status_rd_i)  pend <= |trans_i;
    else                   pend <= pend | (|trans_i);
  end

  assign change_n_o = mode_i ? ~(|det_i) : ~pend;

  AST_DATA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && $past(!mode_i) && $rose(change_n_o)) |-> $past(status_rd_i)); // R9
  AST_TRANS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (|trans_i) |=> pend); // R9
endmodule

// File: rtl/touch_guard_di.sv
module touch_guard_di
  import tdi_pkg::*;
#(
  parameter int NKEYS = 11,
  localparam int IDX_W = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acq_valid,
  input  logic [NKEYS*SIG_W-1:0] sig_flat,
  input  logic [NKEYS*SIG_W-1:0] base_flat,
  input  logic [NKEYS*THR_W-1:0] thr_flat,
  input  logic [DI_W-1:0]        di_limit,
  input  logic                   guard_en,
  input  logic [IDX_W-1:0]       guard_idx,
  input  logic                   change_mode,
  input  logic                   status_rd,
  output logic [NKEYS-1:0]       detect,
  output logic                   change_n
);
  logic [NKEYS-1:0] enter_req;
  logic [NKEYS-1:0] exit_evt;
  logic [NKEYS-1:0] grant;
  logic [NKEYS-1:0] guard_mask;
  logic [NKEYS-1:0] trans;

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    tdi_key_integ u_key (
      .clk         (clk),
      .rst_n       (rst_n),
      .acq_valid   (acq_valid),
      .sig_i       (sig_flat[k*SIG_W +: SIG_W]),
      .base_i      (base_flat[k*SIG_W +: SIG_W]),
      .thr_i       (thr_flat[k*THR_W +: THR_W]),
      .limit_i     (di_limit),
      .grant_i     (grant[k]),
      .det_o       (detect[k]),
      .enter_req_o (enter_req[k]),
      .exit_evt_o  (exit_evt[k])
    );
  end

  tdi_guard_arb #(.N(NKEYS), .IDX_W(IDX_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_req_i  (enter_req),
    .det_i        (detect),
    .guard_en_i   (guard_en),
    .guard_idx_i  (guard_idx),
    .grant_o      (grant),
    .guard_mask_o (guard_mask)
  );

  assign trans = (grant & enter_req) | exit_evt;

  tdi_change #(.N(NKEYS)) u_chg (
    .clk         (clk),
    .rst_n       (rst_n),
    .det_i       (detect),
    .trans_i     (trans),
    .mode_i      (change_mode),
    .status_rd_i (status_rd),
    .change_n_o  (change_n)
  );

  AST_ONE_NEW_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(detect & ~$past(detect) & ~guard_mask) <= 1); // R6
  AST_GUARD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & guard_mask)) |-> ((detect & ~guard_mask) == '0)); // R8
endmodule

// File: tb/tb_touch_guard_di.sv
module tb_touch_guard_di;
  localparam int N = 11;
  localparam int SW = 12;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_valid = 1'b0;
  logic [N*SW-1:0] sig_flat, base_flat;
  logic [N*TW-1:0] thr_flat;
  logic [7:0] di_limit = 8'd3;
  logic guard_en = 1'b0;
  logic [3:0] guard_idx = 4'd10;
  logic change_mode = 1'b0;
  logic status_rd = 1'b0;
  logic [N-1:0] detect;
  logic change_n;

  logic [SW-1:0] sig_a [N];
  logic [SW-1:0] base_a [N];
  logic [TW-1:0] thr_a [N];

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      sig_flat[k*SW +: SW]  = sig_a[k];
      base_flat[k*SW +: SW] = base_a[k];
      thr_flat[k*TW +: TW]  = thr_a[k];
    end
  end

  touch_guard_di dut (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid),
    .sig_flat(sig_flat), .base_flat(base_flat), .thr_flat(thr_flat),
    .di_limit(di_limit), .guard_en(guard_en), .guard_idx(guard_idx),
    .change_mode(change_mode), .status_rd(status_rd),
    .detect(detect), .change_n(change_n)
  );

  task automatic chk(input string req, input logic [N-1:0] exp_det, input logic exp_chg);
    n_chk++;
    if (detect !== exp_det || change_n !== exp_chg) begin
      n_bad++;
      $display("FAIL %s: detect=%b change_n=%b expected detect=%b change_n=%b",
               req, detect, change_n, exp_det, exp_chg);
    end
  endtask

  task automatic acq(input int times, input logic rd = 1'b0);
    for (int i = 0; i < times; i++) begin
      acq_valid = 1'b1;
      status_rd = rd;
      @(posedge clk);
      @(negedge clk);
      acq_valid = 1'b0;
      status_rd = 1'b0;
    end
  endtask

  task automatic read_status();
    status_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset", '0, 1'b1);
  endtask

  task automatic t_threshold_entry();
    sig_a[0] = 12'd980;                 // difference equals threshold
    acq(5);
    chk("R1 equal difference", '0, 1'b1);
    sig_a[0] = 12'd979;
    acq(2);
    chk("R2 below limit", '0, 1'b1);
    acq(1);
    chk("R2 entry at limit", 11'h001, 1'b0);
  endtask

  task automatic t_count_reset();
    sig_a[1] = 12'd900;
    acq(2);
    sig_a[1] = 12'd1000;
    acq(1);
    sig_a[1] = 12'd900;
    acq(2);
    chk("R3 broken run", 11'h001, 1'b0);
    acq(1);
    chk("R3 fresh run", 11'h003, 1'b0);
  endtask

  task automatic t_exit();
    sig_a[0] = 12'd1000; sig_a[1] = 12'd1000;
    acq(2);
    chk("R4 before exit limit", 11'h003, 1'b0);
    sig_a[0] = 12'd900;
    acq(1);                             // key1 exits, key0 count cleared
    chk("R4 key1 exits", 11'h001, 1'b0);
    sig_a[0] = 12'd1000;
    acq(2);
    chk("R4 key0 restarted", 11'h001, 1'b0);
    acq(1);
    chk("R4 key0 exits", '0, 1'b0);
  endtask

  task automatic t_data_change();
    read_status();
    chk("R9 read releases", '0, 1'b1);
    sig_a[2] = 12'd900;
    acq(3);
    chk("R9 entry flags", 11'h004, 1'b0);
    sig_a[2] = 12'd1000;
    acq(3);
    chk("R9 latched after exit", '0, 1'b0);
    read_status();
    sig_a[3] = 12'd900;
    acq(2);
    chk("R9 quiet before", '0, 1'b1);
    acq(1, 1'b1);                        // read coincides with entry
    chk("R9 read with transition", 11'h008, 1'b0);
    read_status();
    chk("R9 later read", 11'h008, 1'b1);
  endtask

  task automatic t_idle();
    sig_a[3] = 12'd1000;
    repeat (6) @(negedge clk);
    chk("R12 no strobe", 11'h008, 1'b1);
    acq(2);
    repeat (4) @(negedge clk);
    acq(1);
    chk("R12 counts kept", '0, 1'b0);
    read_status();
  endtask

  task automatic t_touch_mode();
    change_mode = 1'b1;
    @(negedge clk);
    chk("R10 none touched", '0, 1'b1);
    sig_a[4] = 12'd900;
    acq(3);
    chk("R10 touched", 11'h010, 1'b0);
    sig_a[4] = 12'd1000;
    acq(3);
    chk("R10 released", '0, 1'b1);
    change_mode = 1'b0;
    read_status();
  endtask

  task automatic t_unused();
    thr_a[5] = 8'd0;
    sig_a[5] = 12'd0;
    acq(5);
    chk("R5 zero threshold", '0, 1'b1);
    sig_a[5] = 12'd1000;
    thr_a[5] = 8'd20;
  endtask

  task automatic t_arbitration();
    sig_a[6] = 12'd900; sig_a[7] = 12'd900; sig_a[8] = 12'd900;
    acq(3);
    chk("R6 lowest wins", 11'h040, 1'b0);
    acq(1);
    chk("R6 held count enters", 11'h0C0, 1'b0);
    acq(1);
    chk("R6 third enters", 11'h1C0, 1'b0);
    sig_a[6] = 12'd1000; sig_a[7] = 12'd1000; sig_a[8] = 12'd1000;
    acq(3);
    chk("R6 all exit", '0, 1'b0);
    di_limit = 8'd0;
    sig_a[9] = 12'd900;
    acq(1);
    chk("R2 limit zero", 11'h200, 1'b0);
    sig_a[9] = 12'd1000;
    acq(1);
    chk("R4 limit zero exit", '0, 1'b0);
    di_limit = 8'd3;
    read_status();
  endtask

  task automatic t_guard();
    guard_en = 1'b1;
    sig_a[10] = 12'd900;
    acq(3);
    chk("R7 guard enters", 11'h400, 1'b0);
    sig_a[0] = 12'd900;
    acq(5);
    chk("R7 guard blocks", 11'h400, 1'b0);
    sig_a[10] = 12'd1000;
    acq(3);
    chk("R7 blocked on guard exit", '0, 1'b0);
    acq(1);
    chk("R7 enters after guard", 11'h001, 1'b0);
    sig_a[10] = 12'd900;
    acq(5);
    chk("R8 guard waits", 11'h001, 1'b0);
    sig_a[0] = 12'd1000;
    acq(3);
    chk("R8 still waiting on exit", '0, 1'b0);
    acq(1);
    chk("R8 guard enters late", 11'h400, 1'b0);
    sig_a[10] = 12'd1000;
    acq(3);
    guard_en = 1'b0;
    sig_a[10] = 12'd900; sig_a[1] = 12'd900;
    acq(3);
    chk("R7 disabled guard normal", 11'h002, 1'b0);
    acq(1);
    chk("R7 disabled second", 11'h402, 1'b0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      sig_a[k] = 12'd1000; base_a[k] = 12'd1000; thr_a[k] = 8'd20;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold_entry();
    t_count_reset();
    t_exit();
    t_data_change();
    t_idle();
    t_touch_mode();
    t_unused();
    t_arbitration();
    t_guard();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule